// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block steers four level-sensitive shared interrupt lines (PIRQ A, B, C and D) onto sixteen legacy interrupt-controller inputs. Each shared line has its own eight-bit route byte. The byte holds the number of the legacy input that the line drives. If the number is sixteen or more, the line is disconnected. The route bytes are programmed through a plain byte-addressed write port with per-lane enables. A level matrix holds one bit for each legacy input and each shared line, indexed irq*4 + pirq. Each legacy output is the registered OR of its row of that matrix.

A change of a shared line's level touches only that line's own matrix bit. A write to any route byte clears the whole matrix and rebuilds it from the present levels of all four lines under the new routing. A separate swizzle stage converts a device slot number and its interrupt pin (INTA to INTD) into the shared line that the pin lands on. Boards use this swizzle so that devices spread their interrupts over the four lines.

Top module: `irq_route_top`

## Requirements
- R1: After reset every irq_out bit is 0, and every route byte holds 0x80, so raising any pirq_in line leaves all of irq_out at 0.
- R2: The route bytes for PIRQ A, B, C and D sit at byte addresses 0x60, 0x61, 0x62 and 0x63. A write addresses an aligned 32-bit word through wr_addr[7:2], and wr_addr[1:0] is ignored. Lane k carries byte address word*4+k in wr_data[8k+7:8k] and is written only when wr_be[k] is 1.
- R3: A route value from 0 to 15 connects the line to the irq_out bit of that number. A value of 16 or more disconnects it, so that line's level reaches no output.
- R4: irq_out[i] is the OR of every pirq_in line whose route equals i. It is registered, so a level sampled at a clock edge appears on irq_out right after that same edge.
- R5: A write whose word address holds no route byte, or whose enabled lanes miss every route byte, leaves all routing unchanged.
- R6: A route write takes effect at the edge that accepts it. The matrix is rebuilt from the pirq_in levels sampled at that edge, so an output fed only by the old route drops at that edge.
- R7: A level change on pirq_in that falls in the same cycle as a route write is counted under the new routing.
- R8: sw_pirq is a registered (sw_pin + sw_slot - 1) mod 4, where sw_pin is 0 for INTA through 3 for INTD and a result of 0 means PIRQ A.
- R9: A single 32-bit write at 0x60 with all four byte enables updates all four route bytes in one cycle.
- R10: Asserting rst while outputs are active clears irq_out at the next edge and restores all routes to disconnected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the route bytes |
| wr_addr | input | 8 | Byte address; bits [7:2] pick the word |
| wr_be | input | 4 | Byte-lane enables |
| wr_data | input | 32 | Write data, lane k in bits [8k+7:8k] |
| pirq_in | input | 4 | Shared interrupt line levels, bit 0 = PIRQ A |
| irq_out | output | 16 | Legacy interrupt-controller input levels |
| sw_slot | input | 5 | Device slot number for the swizzle |
| sw_pin | input | 2 | Device interrupt pin, 0 = INTA |
| sw_pirq | output | 2 | Registered shared line for that slot and pin |

## Verification
A route write and a level change on a shared line can land on the same clock edge. The write forces a full matrix rebuild, and the level change would otherwise update a single bit. The bench provokes this case twice from one negative edge. First it writes a new route while it raises the line being routed. Later it disconnects one line while it raises that same line. The result is judged by the irq_out pattern one edge later. The newly routed line must appear on its new output. The disconnected line must appear nowhere, and no output may be left over from the old routing.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int ROUTE_W = 8;

  typedef logic [ROUTE_W-1:0] route_t;

  // byte lane that holds a given byte address
  function automatic int lane_of(input int byte_addr, input int nbytes);
    return byte_addr % nbytes;
  endfunction

  // word index that holds a given byte address
  function automatic int word_of(input int byte_addr, input int nbytes);
    return byte_addr / nbytes;
  endfunction

endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int     NUM_PIRQ   = 4,
  parameter int     ADDR_W     = 8,
  parameter int     DATA_W     = 32,
  parameter int     ROUTE_BASE = 'h60,
  parameter route_t ROUTE_RST  = 8'h80
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [DATA_W/8-1:0]            wr_be,
  input  logic [DATA_W-1:0]              wr_data,
  output logic [NUM_PIRQ-1:0][ROUTE_W-1:0] route_q,
  output logic [NUM_PIRQ-1:0][ROUTE_W-1:0] route_nx,
  output logic                           route_chg
);

  localparam int NBYTES = DATA_W / 8;
  localparam int LB     = $clog2(NBYTES);
  localparam int WA_W   = ADDR_W - LB;

  logic [NUM_PIRQ-1:0] hit;
  logic [WA_W-1:0]     word_addr;

  assign word_addr = wr_addr[ADDR_W-1:LB];

  for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_route
    localparam int BADDR = ROUTE_BASE + p;
    localparam int LANE  = lane_of(BADDR, NBYTES);
    localparam int WORD  = word_of(BADDR, NBYTES);

    assign hit[p] = wr_en && (word_addr == WA_W'(WORD)) && wr_be[LANE];

    always_comb begin
      route_nx[p] = route_q[p];
      if (hit[p]) route_nx[p] = wr_data[LANE*8 +: 8];
    end

    always_ff @(posedge clk) begin
      if (rst) route_q[p] <= ROUTE_RST;
      else     route_q[p] <= route_nx[p];
    end
  end

  assign route_chg = |hit;

  // R5
  route_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(route_q));

endmodule

// File: rtl/irq_level_matrix.sv
module irq_level_matrix
  import irq_route_pkg::*;
#(
  parameter int NUM_PIRQ = 4,
  parameter int NUM_IRQ  = 16
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_PIRQ-1:0][ROUTE_W-1:0] route_nx,
  input  logic [NUM_PIRQ-1:0][ROUTE_W-1:0] route_q,
  input  logic                             rebuild,
  input  logic [NUM_PIRQ-1:0]              pirq_in,
  output logic [NUM_IRQ-1:0]               irq_out
);

  localparam int CELLS = NUM_IRQ * NUM_PIRQ;

  logic [CELLS-1:0]   lvl_q;
  logic [CELLS-1:0]   lvl_nx;
  logic [NUM_IRQ-1:0] irq_nx;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_pirq
      localparam int IDX = i * NUM_PIRQ + p;
      logic sel;
      assign sel = (route_nx[p] == ROUTE_W'(i));
      always_comb begin
        if (rebuild)  lvl_nx[IDX] = sel & pirq_in[p];
        else if (sel) lvl_nx[IDX] = pirq_in[p];
        else          lvl_nx[IDX] = lvl_q[IDX];
      end
    end
    assign irq_nx[i] = |lvl_nx[i*NUM_PIRQ +: NUM_PIRQ];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q   <= '0;
      irq_out <= '0;
    end else begin
      lvl_q   <= lvl_nx;
      irq_out <= irq_nx;
    end
  end

  // ---- checks ----
  logic                rst_q;
  logic [NUM_PIRQ-1:0] pirq_q;

  always_ff @(posedge clk) begin
    rst_q  <= rst;
    pirq_q <= pirq_in;
    if (rst_q && !rst) begin
      // R1
      reset_clear_chk: assert (irq_out == '0 && lvl_q == '0);
    end
  end

  for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_colchk
    logic [NUM_IRQ-1:0] col;
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_c
      assign col[i] = lvl_q[i*NUM_PIRQ + p];
    end
    // R3
    detached_col_chk: assert property (@(posedge clk) disable iff (rst)
      (route_q[p] >= ROUTE_W'(NUM_IRQ)) |-> (col == '0));
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_srcchk
    logic [NUM_PIRQ-1:0] src;
    for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_s
      assign src[p] = (route_q[p] == ROUTE_W'(i)) && pirq_q[p];
    end
    // R4
    irq_source_chk: assert property (@(posedge clk) disable iff (rst || rst_q)
      irq_out[i] |-> (|src));
  end

endmodule

// File: rtl/irq_swizzle.sv
module irq_swizzle #(
  parameter int NUM_PIRQ = 4,
  parameter int SLOT_W   = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [SLOT_W-1:0]           slot,
  input  logic [$clog2(NUM_PIRQ)-1:0] pin,
  output logic [$clog2(NUM_PIRQ)-1:0] pirq_o
);

  localparam int PW = $clog2(NUM_PIRQ);

  logic [PW-1:0] pirq_nx;

  always_comb begin
    int sum;
    sum     = int'(slot) + int'(pin) + NUM_PIRQ - 1;
    pirq_nx = PW'(sum % NUM_PIRQ);
  end

  always_ff @(posedge clk) begin
    if (rst) pirq_o <= '0;
    else     pirq_o <= pirq_nx;
  end

  // R8
  slot_one_chk: assert property (@(posedge clk) disable iff (rst)
    (slot == SLOT_W'(1)) |=> (pirq_o == $past(pin)));

endmodule

// File: rtl/irq_route_top.sv
module irq_route_top
  import irq_route_pkg::*;
#(
  parameter int     NUM_PIRQ   = 4,
  parameter int     NUM_IRQ    = 16,
  parameter int     ADDR_W     = 8,
  parameter int     DATA_W     = 32,
  parameter int     ROUTE_BASE = 'h60,
  parameter route_t ROUTE_RST  = 8'h80,
  parameter int     SLOT_W     = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [DATA_W/8-1:0]         wr_be,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic [NUM_PIRQ-1:0]         pirq_in,
  output logic [NUM_IRQ-1:0]          irq_out,
  input  logic [SLOT_W-1:0]           sw_slot,
  input  logic [$clog2(NUM_PIRQ)-1:0] sw_pin,
  output logic [$clog2(NUM_PIRQ)-1:0] sw_pirq
);

  logic [NUM_PIRQ-1:0][ROUTE_W-1:0] route_q;
  logic [NUM_PIRQ-1:0][ROUTE_W-1:0] route_nx;
  logic                             route_chg;

  irq_route_regs #(
    .NUM_PIRQ(NUM_PIRQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .ROUTE_BASE(ROUTE_BASE), .ROUTE_RST(ROUTE_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_be(wr_be), .wr_data(wr_data),
    .route_q(route_q), .route_nx(route_nx), .route_chg(route_chg)
  );

  irq_level_matrix #(
    .NUM_PIRQ(NUM_PIRQ), .NUM_IRQ(NUM_IRQ)
  ) u_matrix (
    .clk(clk), .rst(rst), .route_nx(route_nx), .route_q(route_q),
    .rebuild(route_chg), .pirq_in(pirq_in), .irq_out(irq_out)
  );

  irq_swizzle #(
    .NUM_PIRQ(NUM_PIRQ), .SLOT_W(SLOT_W)
  ) u_swz (
    .clk(clk), .rst(rst), .slot(sw_slot), .pin(sw_pin), .pirq_o(sw_pirq)
  );

endmodule

// File: tb/sim_irq_route_top.sv
module sim_irq_route_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [3:0]  wr_be;
  logic [31:0] wr_data;
  logic [3:0]  pirq_in;
  logic [15:0] irq_out;
  logic [4:0]  sw_slot;
  logic [1:0]  sw_pin;
  logic [1:0]  sw_pirq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_route_top u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
    .wr_data(wr_data), .pirq_in(pirq_in), .irq_out(irq_out),
    .sw_slot(sw_slot), .sw_pin(sw_pin), .sw_pirq(sw_pirq)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // one write cycle, with pirq_in driven in the same cycle
  task automatic wr(input logic [7:0] a, input logic [3:0] be,
                    input logic [31:0] d, input logic [3:0] lv);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_be = be; wr_data = d; pirq_in = lv;
    @(negedge clk);
    wr_en = 1'b0; wr_be = '0;
  endtask

  task automatic lvl(input logic [3:0] lv);
    @(negedge clk);
    pirq_in = lv;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 reset irq", irq_out, 16'h0000);
    lvl(4'hF);
    chk("R1 all detached after reset", irq_out, 16'h0000);
    lvl(4'h0);
  endtask

  task automatic t_word_write;
    // A=5 B=9 C=5 D=15
    wr(8'h60, 4'hF, 32'h0F05_0905, 4'hF);
    chk("R9 word write all four", irq_out, 16'h8220);
    lvl(4'h1); chk("R4 A only", irq_out, 16'h0020);
    lvl(4'h4); chk("R4 C only", irq_out, 16'h0020);
    lvl(4'h5); chk("R4 A or C shared", irq_out, 16'h0020);
    lvl(4'h8); chk("R4 D only", irq_out, 16'h8000);
    lvl(4'h0); chk("R4 all low", irq_out, 16'h0000);
  endtask

  task automatic t_byte_lane;
    wr(8'h61, 4'b0010, 32'h0000_0300, 4'h0);
    lvl(4'h2); chk("R2 lane1 route B to 3", irq_out, 16'h0008);
    wr(8'h60, 4'b1000, 32'h1000_0000, 4'h2);
    lvl(4'h8); chk("R3 value 16 detaches D", irq_out, 16'h0000);
    wr(8'h60, 4'b1000, 32'h0F00_0000, 4'h8);
    chk("R3 value 15 connects D", irq_out, 16'h8000);
  endtask

  task automatic t_ignored;
    wr(8'h64, 4'hF, 32'h0000_0000, 4'hF);
    chk("R5 other word ignored", irq_out, 16'h8028);
    wr(8'h60, 4'h0, 32'h0000_0000, 4'hF);
    chk("R5 no lanes ignored", irq_out, 16'h8028);
    lvl(4'h0);
  endtask

  task automatic t_rebuild;
    lvl(4'h1); chk("R6 A on old irq", irq_out, 16'h0020);
    wr(8'h60, 4'b0001, 32'h0000_0007, 4'h1);
    chk("R6 A moved to irq7", irq_out, 16'h0080);
  endtask

  task automatic t_same_cycle;
    lvl(4'h0); chk("R7 idle", irq_out, 16'h0000);
    wr(8'h60, 4'b0010, 32'h0000_0200, 4'h2);
    chk("R7 route and raise B together", irq_out, 16'h0004);
    wr(8'h60, 4'b0001, 32'h0000_0080, 4'h3);
    chk("R7 detach and raise A together", irq_out, 16'h0004);
  endtask

  task automatic t_swizzle;
    for (int s = 0; s < 32; s++) begin
      for (int p = 0; p < 4; p++) begin
        @(negedge clk);
        sw_slot = 5'(s); sw_pin = 2'(p);
        @(negedge clk);
        chk($sformatf("R8 swizzle slot %0d pin %0d", s, p),
            16'(sw_pirq), 16'((p + s + 3) % 4));
      end
    end
  endtask

  task automatic t_reset_mid;
    lvl(4'hF); chk("R10 active before reset", irq_out, 16'h8024);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); chk("R10 reset clears irq", irq_out, 16'h0000);
    rst = 1'b0;
    @(negedge clk); chk("R10 routes detached again", irq_out, 16'h0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_be = '0; wr_data = '0;
    pirq_in = '0; sw_slot = '0; sw_pin = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_word_write();
    t_byte_lane();
    t_ignored();
    t_rebuild();
    t_same_cycle();
    t_swizzle();
    t_reset_mid();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule